// File: doc/BRIEF.md
# Copy-Control Line Data Serializer

This block sends a 20-bit copy-generation management word as a serial bit stream on one chosen video line. A line-timing controller outside the block issues a one-cycle start pulse where the line's data window begins. It also issues a bit-rate enable that sets the pace of the stream. The block decides on each start whether the current field is allowed to carry the word, latches the whole frame, and then presents one bit per bit-rate enable. A valid flag marks the bits that are being sent.

The word has 14 data bits and a 6-bit check sequence. Ten data bits come from a head field and four from a tail field. The tail field carries copy-control data only. A control input picks where the check sequence comes from: either the block computes it from the 14 data bits, or it copies six register bits unchanged. Transmission is enabled separately for odd and for even fields. It is allowed only when the standard-select input indicates the 525-line (NTSC) standard. A wide-screen enable input is present with the other control bits. It belongs to the 625-line signalling path and never starts this stream.

Top module: `cgms_line_serializer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it returns high, `valid_o` and `sdata_o` are 0. A reset during a frame stops that frame.
- R2: An accepted start produces exactly 20 bit periods. `valid_o` goes high on the clock edge that accepts the start. It stays high through 20 `bit_tick` pulses and goes low on the edge that takes the 20th pulse.
- R3: Bits 1 to 10 of the frame are `head_data[0]` through `head_data[9]`, in that order. Bits 11 to 14 are `tail_data[0]` through `tail_data[3]`.
- R4: With `crc_internal`=1, bits 15 to 20 are a CRC over the 14 data bits, taken in transmit order. The generator polynomial is x^6+x+1 and the register starts at all ones. Each bit updates the register like this: feedback = crc[5] XOR bit; crc = {crc[4:0],0}, and crc is XORed with 6'b000011 when feedback is 1. The result is sent crc[5] first and crc[0] last.
- R5: With `crc_internal`=0, bits 15 to 20 are `reg_crc[5]` down to `reg_crc[0]`.
- R6: On an odd field (`field_odd`=1), a start is accepted only when `odd_en`=1.
- R7: On an even field (`field_odd`=0), a start is accepted only when `even_en`=1.
- R8: When `std_pal`=1, no start is accepted and `valid_o` stays 0.
- R9: `wide_en` has no effect. It neither starts a frame nor alters a frame.
- R10: A start that arrives while `valid_o` is high is ignored. This includes a start in the same cycle as the 20th `bit_tick`. The frame in progress continues unchanged, and no new frame follows.
- R11: `sdata_o` changes only on a clock edge where `bit_tick` is 1, or on the edge that accepts a start. Between bit-rate enables it holds its value.
- R12: `sdata_o` is 0 whenever `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| head_data | input | 10 | Frame data bits 1 to 10, LSB sent first |
| tail_data | input | 4 | Frame data bits 11 to 14, LSB sent first |
| reg_crc | input | 6 | Check bits used when the internal CRC is off |
| crc_internal | input | 1 | 1: compute the CRC; 0: send `reg_crc` |
| odd_en | input | 1 | Allows transmission on odd fields |
| even_en | input | 1 | Allows transmission on even fields |
| wide_en | input | 1 | Wide-screen signalling enable; no effect here |
| field_odd | input | 1 | 1 when the current field is odd |
| std_pal | input | 1 | 1 selects the 625-line standard (transmission blocked) |
| start | input | 1 | One-cycle pulse at the start of the data window |
| bit_tick | input | 1 | Bit-rate enable; advances the stream by one bit |
| sdata_o | output | 1 | Serial frame bit |
| valid_o | output | 1 | High while the frame's 20 bits are presented |

## Verification
Two functions can meet in one cycle: the start qualifier, which may load a new frame, and the shifter's final advance, which ends the current one. The bench drives a start pulse in the same cycle as the 20th bit-rate enable, and also drives one in the middle of a frame with changed head data. In both cases the captured frame must match the bench's model bit for bit. `valid_o` must fall exactly after the 20th enable and stay low in the cycles that follow, which shows that the late start neither restarted nor extended the stream.

// File: rtl/cgms_pkg.sv
// Package: shared frame geometry and control-bit bundle for the copy-control
// line serializer. Assumes a 14-bit data field and a 6-bit check sequence.
package cgms_pkg;
    localparam int CGMS_HEAD_W = 10;
    localparam int CGMS_TAIL_W = 4;
    localparam int CGMS_DATA_W = CGMS_HEAD_W + CGMS_TAIL_W;
    localparam int CGMS_CRC_W  = 6;
    localparam int CGMS_FRAME_W = CGMS_DATA_W + CGMS_CRC_W;

    // Per-frame control bits as seen by the start qualifier.
    typedef struct packed {
        logic odd_en;
        logic even_en;
        logic crc_internal;
    } cgms_ctl_t;
endpackage

// File: rtl/cgms_crc_gen.sv
// Module: cgms_crc_gen
// Combinational serial-equivalent CRC over DATA_W bits, bit 0 first.
// Assumes POLY lists the low-order taps (x^CRC_W term implicit) and SEED is
// the preset. No state; result is valid in the same cycle as data.
module cgms_crc_gen #(
    parameter int                DATA_W = 14,
    parameter int                CRC_W  = 6,
    parameter logic [CRC_W-1:0]  POLY   = 6'b000011,
    parameter logic [CRC_W-1:0]  SEED   = '1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);
    // Unrolled bit-serial LFSR in transmit order.
    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = SEED;
        for (int i = 0; i < DATA_W; i++) begin
            fb  = acc[CRC_W-1] ^ data_i[i];
            acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        crc_o = acc;
    end
endmodule

// File: rtl/cgms_field_gate.sv
// Module: cgms_field_gate
// Decides whether a start pulse may load a frame: only when idle, on the
// 525-line standard, and with the enable matching the current field parity.
// Assumes start is a single-cycle pulse.
module cgms_field_gate
    import cgms_pkg::*;
(
    input  logic      start_i,
    input  logic      busy_i,
    input  logic      field_odd_i,
    input  logic      std_pal_i,
    input  cgms_ctl_t ctl_i,
    output logic      load_o
);
    logic field_ok;

    // Select the enable that belongs to the current field.
    always_comb field_ok = field_odd_i ? ctl_i.odd_en : ctl_i.even_en;

    // Qualify the start pulse.
    always_comb load_o = start_i && !busy_i && !std_pal_i && field_ok;
endmodule

// File: rtl/cgms_shifter.sv
// Module: cgms_shifter
// Frame shift register with bit counter. Loads FRAME_W bits on load_i,
// presents bit 0 first, shifts right with zero fill on each bit_tick_i and
// drops busy after the last bit. Assumes load_i is only raised when idle.
module cgms_shifter #(
    parameter int FRAME_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               bit_tick_i,
    output logic               sdata_o,
    output logic               busy_o
);
    localparam int                CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] sr;
    logic [CNT_W-1:0]   cnt;

    // Load, advance and terminate the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr     <= '0;
            cnt    <= '0;
            busy_o <= 1'b0;
        end else if (load_i) begin
            sr     <= frame_i;
            cnt    <= '0;
            busy_o <= 1'b1;
        end else if (busy_o && bit_tick_i) begin
            sr <= sr >> 1;
            if (cnt == LAST) begin
                cnt    <= '0;
                busy_o <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Serial output is the register's low bit.
    always_comb sdata_o = sr[0];

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    assert_end_on_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && bit_tick_i && cnt == LAST) |=> !busy_o);

    assert_hold_between_ticks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !bit_tick_i) |=> (busy_o && $stable(sdata_o) && $stable(cnt)));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sdata_o);
endmodule

// File: rtl/cgms_line_serializer.sv
// Module: cgms_line_serializer (top)
// Assembles the 20-bit copy-control frame (head, tail, check bits), picks
// internal or register check bits, qualifies the start by field and standard
// and serializes the frame at the bit-rate enable.
// Assumes start and bit_tick come from an external line-timing controller.
module cgms_line_serializer
    import cgms_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CGMS_HEAD_W-1:0]  head_data,
    input  logic [CGMS_TAIL_W-1:0]  tail_data,
    input  logic [CGMS_CRC_W-1:0]   reg_crc,
    input  logic                    crc_internal,
    input  logic                    odd_en,
    input  logic                    even_en,
    input  logic                    wide_en,
    input  logic                    field_odd,
    input  logic                    std_pal,
    input  logic                    start,
    input  logic                    bit_tick,
    output logic                    sdata_o,
    output logic                    valid_o
);
    logic [CGMS_DATA_W-1:0]  data_word;
    logic [CGMS_CRC_W-1:0]   crc_calc;
    logic [CGMS_CRC_W-1:0]   crc_sel;
    logic [CGMS_FRAME_W-1:0] frame;
    logic                    load;
    logic                    busy;
    cgms_ctl_t               ctl;

    // Bundle the control inputs for the qualifier.
    always_comb ctl = '{odd_en: odd_en, even_en: even_en, crc_internal: crc_internal};

    // Data field in transmit order: head first, tail last.
    always_comb data_word = {tail_data, head_data};

    cgms_crc_gen #(
        .DATA_W (CGMS_DATA_W),
        .CRC_W  (CGMS_CRC_W),
        .POLY   (6'b000011),
        .SEED   ('1)
    ) u_crc (
        .data_i (data_word),
        .crc_o  (crc_calc)
    );

    // Choose computed or register check bits.
    always_comb crc_sel = ctl.crc_internal ? crc_calc : reg_crc;

    // Data occupies the low frame bits.
    always_comb frame[CGMS_DATA_W-1:0] = data_word;

    // Check bits follow, most significant first.
    for (genvar k = 0; k < CGMS_CRC_W; k++) begin : g_crc_order
        assign frame[CGMS_DATA_W + k] = crc_sel[CGMS_CRC_W-1-k];
    end

    cgms_field_gate u_gate (
        .start_i     (start),
        .busy_i      (busy),
        .field_odd_i (field_odd),
        .std_pal_i   (std_pal),
        .ctl_i       (ctl),
        .load_o      (load)
    );

    cgms_shifter #(
        .FRAME_W (CGMS_FRAME_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .frame_i    (frame),
        .bit_tick_i (bit_tick),
        .sdata_o    (sdata_o),
        .busy_o     (busy)
    );

    // Flag mirrors the shifter's activity.
    always_comb valid_o = busy;

    assert_field_std_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(start && !std_pal && (field_odd ? odd_en : even_en)));

    assert_wide_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && wide_en && !odd_en && !even_en && !valid_o) |=> !valid_o);

    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && start && !bit_tick) |=> valid_o);
endmodule

// File: tb/cgms_line_serializer_test.sv
module cgms_line_serializer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] head_data = '0;
    logic [3:0] tail_data = '0;
    logic [5:0] reg_crc = '0;
    logic       crc_internal = 1'b0, odd_en = 1'b0, even_en = 1'b0, wide_en = 1'b0;
    logic       field_odd = 1'b0, std_pal = 1'b0, start = 1'b0, bit_tick = 1'b0;
    logic       sdata_o, valid_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cgms_line_serializer uut (.*);

    // Vector: [26] expect tx, [25:16] head, [15:12] tail, [11:6] reg crc,
    // [5] crc_internal, [4] odd_en, [3] even_en, [2] wide_en, [1] field_odd, [0] std_pal
    localparam int NV = 9;
    localparam logic [26:0] VEC [NV] = '{
        {1'b1, 10'h2A5, 4'hC, 6'h15, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b1, 10'h000, 4'h0, 6'h3F, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 10'h3FF, 4'hF, 6'h2A, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {1'b0, 10'h155, 4'h5, 6'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b0, 10'h155, 4'h5, 6'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {1'b0, 10'h0F0, 4'h3, 6'h11, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        {1'b0, 10'h0F0, 4'h3, 6'h11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {1'b1, 10'h1C3, 4'h9, 6'h07, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {1'b1, 10'h3A1, 4'h6, 6'h1B, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}
    };
    localparam string VTAG [NV] = '{
        "R3 R4 R6", "R4 R7", "R5 R6", "R7", "R6", "R8", "R9", "R9 R4", "R9 R5"
    };

    // Expected frame built from the requirement text (bit 0 sent first).
    function automatic logic [19:0] model(input logic [26:0] v);
        logic [13:0] d;
        logic [5:0]  c, s;
        logic        fb;
        logic [19:0] f;
        d = {v[15:12], v[25:16]};
        c = 6'h3F;
        for (int i = 0; i < 14; i++) begin
            fb = c[5] ^ d[i];
            c  = {c[4:0], 1'b0} ^ (fb ? 6'h03 : 6'h00);
        end
        s = v[5] ? c : v[11:6];
        f[13:0] = d;
        for (int k = 0; k < 6; k++) f[14+k] = s[5-k];
        return f;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [26:0] v);
        head_data = v[25:16]; tail_data = v[15:12]; reg_crc = v[11:6];
        crc_internal = v[5]; odd_en = v[4]; even_en = v[3]; wide_en = v[2];
        field_odd = v[1]; std_pal = v[0];
    endtask

    // Runs one frame; a second start rides on the tick of bit restart_at (-1: none).
    task automatic run_frame(input logic [26:0] v, input string req, input int restart_at);
        logic [19:0] rx, exp;
        int          vbad, sbad;
        rx = '0; vbad = 0; sbad = 0;
        exp = v[26] ? model(v) : 20'h0;
        @(negedge clk); apply(v); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int b = 0; b < 20; b++) begin
            logic s1, v1;
            s1 = sdata_o; v1 = valid_o;
            @(negedge clk);
            if (s1 !== sdata_o || v1 !== valid_o) sbad++;
            if (v1 !== v[26]) vbad++;
            rx[b] = s1;
            bit_tick = 1'b1;
            if (b == restart_at) begin
                start = 1'b1; head_data = ~head_data; reg_crc = ~reg_crc;
            end
            @(negedge clk); bit_tick = 1'b0; start = 1'b0;
        end
        check(rx === exp, req, "frame bits", 32'(rx), 32'(exp));
        check(vbad == 0, v[26] ? "R2" : req, "valid mismatches", 32'(vbad), 0);
        check(sbad == 0, "R11", "unstable samples between ticks", 32'(sbad), 0);
        check(valid_o === 1'b0 && sdata_o === 1'b0, "R2 R12", "end of frame idle",
              {30'h0, valid_o, sdata_o}, 0);
        repeat (3) @(negedge clk);
        check(valid_o === 1'b0, restart_at >= 0 ? "R10" : "R2", "no follow-on frame",
              32'(valid_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(valid_o === 1'b0 && sdata_o === 1'b0, "R1", "outputs in reset",
              {30'h0, valid_o, sdata_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid_o === 1'b0 && sdata_o === 1'b0, "R1 R12", "outputs after reset",
              {30'h0, valid_o, sdata_o}, 0);

        for (int i = 0; i < NV; i++) run_frame(VEC[i], VTAG[i], -1);

        // Start in mid-frame with altered data: ignored.
        run_frame(VEC[0], "R10", 5);
        // Start coinciding with the final tick: ignored, no new frame.
        run_frame(VEC[2], "R10", 19);

        // Reset during a frame stops it.
        @(negedge clk); apply(VEC[7]); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int t = 0; t < 3; t++) begin
            bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0; @(negedge clk);
        end
        check(valid_o === 1'b1, "R2", "frame active before reset", 32'(valid_o), 1);
        rst_n = 1'b0; @(negedge clk);
        check(valid_o === 1'b0 && sdata_o === 1'b0, "R1", "reset mid-frame",
              {30'h0, valid_o, sdata_o}, 0);
        rst_n = 1'b1; @(negedge clk);
        run_frame(VEC[7], "R1 R4", -1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule